// File: doc/BRIEF.md
# Power Controller Fault Supervisor

This block sequences the switching of an off-line power controller from digital fault flags and supply-level comparator outputs. It decides, every clock, whether the gate pulses may run, whether the high-voltage start-up current source should charge the supply capacitor, and when a soft-start must be requested. Analog comparators and the current source sit outside; a periodic `tick` input paces the overload fault timer.

Non-latching stop conditions (supply overvoltage, low bulk voltage, external disable, over-temperature) only park the pulses while they last. A sustained overload, or the supply sagging to the low threshold while the current source is already on, enters a protection mode that discharges and recharges the supply twice before retrying. A permanent-latch input holds the block off until the supply collapses below the release level.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: After reset the state code is 0 (off): pulses disabled, current source enabled; once `vcc_ge_start` is seen the state becomes 1 (run) with a soft-start request, or 2 (hold) if a stop condition is present. State codes: 0 off, 1 run, 2 hold, 3 protect-discharge-1, 4 protect-charge-1, 5 protect-discharge-2, 6 protect-charge-2, 7 latched.
- R2: In run or hold, any of `vcc_ovp`, `brownout`, `ext_disable`, `over_temp` moves the state to hold with pulses off at the next edge; when all are clear the state returns to run.
- R3: While `overload` is high in run or hold, the fault timer advances once per `tick`; `overload` low clears it; after FAULT_TICKS ticks the state enters 3 on the following edge.
- R4: The fault timer keeps advancing while the state is hold, so an overload can force protection from hold.
- R5: Protection runs 3 to 4 when `vcc_lt_latchend`, 4 to 5 when `vcc_ge_start`, 5 to 6 when `vcc_lt_latchend`, and 6 to run (with soft-start) when `vcc_ge_start`; pulses are off throughout, the current source is on only in 4 and 6.
- R6: In run and hold the current source turns on after `vcc_lt_min` is seen and off after `vcc_ge_start` is seen.
- R7: In run or hold, `vcc_lt_uv` together with `hv_active` enters state 3; `vcc_lt_uv` with `hv_active` low does not.
- R8: `perm_latch` moves any state to 7; in 7 pulses are off, the source turns on after `vcc_lt_latchend` and off after `vcc_ge_start`, and the state leaves to 0 only when `vcc_lt_release` is seen, even once `perm_latch` has dropped.
- R9: Priority is permanent latch, then protection entry, then stop conditions, then run.
- R10: `softstart_req` is high for exactly one cycle, in the first cycle of each entry into run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Fault-timer time base, one-cycle pulse |
| overload | input | 1 | Feedback asks for maximum power |
| brownout | input | 1 | Bulk voltage too low |
| ext_disable | input | 1 | External disable request |
| perm_latch | input | 1 | External permanent latch request |
| vcc_ovp | input | 1 | Supply overvoltage |
| over_temp | input | 1 | Die over-temperature |
| vcc_ge_start | input | 1 | Supply at or above start level |
| vcc_lt_min | input | 1 | Supply below minimum running level |
| vcc_lt_latchend | input | 1 | Supply below latch-end level |
| vcc_lt_uv | input | 1 | Supply below the low (about 9 V) threshold |
| vcc_lt_release | input | 1 | Supply below latch-release level |
| hv_active | input | 1 | Current source reported on |
| pulse_en | output | 1 | Gate pulses allowed |
| hv_en | output | 1 | Start-up current source enable |
| softstart_req | output | 1 | One-cycle soft-start request |
| state_o | output | 3 | State code per R1 |

## Verification
The bench builds the block with FAULT_TICKS set to 4 instead of the default 80, and drives `tick` by hand, so timer expiry, the clear-on-release behaviour and expiry from the hold state all fit in a handful of ticks. A bench-side supply voltage in millivolts is turned into the five comparator flags, which lets every protection and latch phase be walked with exact level crossings.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_PDIS1 = 3'd3,
    ST_PCHG1 = 3'd4,
    ST_PDIS2 = 3'd5,
    ST_PCHG2 = 3'd6,
    ST_LATCH = 3'd7
  } pfs_state_e;

  function automatic logic is_active(pfs_state_e s);
    return (s == ST_RUN) || (s == ST_HOLD);
  endfunction

  function automatic pfs_state_e start_target(logic stop);
    return stop ? ST_HOLD : ST_RUN;
  endfunction

  // set/clear hysteresis step
  function automatic logic hyst_next(logic q, logic set_c, logic clr_c);
    if (set_c) return 1'b1;
    if (clr_c) return 1'b0;
    return q;
  endfunction

endpackage

// File: rtl/pfs_fault_timer.sv
`timescale 1ns/1ps
module pfs_fault_timer #(
  parameter int unsigned FAULT_TICKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_en,
  output logic expired,
  output logic idle
);
  localparam int unsigned CW = $clog2(FAULT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FAULT_TICKS);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] cnt_next(logic [CW-1:0] c, logic en, logic t);
    if (!en) return '0;
    if (t && (c != LIMIT)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, run_en, tick);
  end

  assign expired = (cnt_q == LIMIT);
  assign idle    = (cnt_q == '0);
endmodule

// File: rtl/pfs_supply_ctrl.sv
`timescale 1ns/1ps
module pfs_supply_ctrl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfs_state_e state,
  input  logic       vcc_ge_start,
  input  logic       vcc_lt_min,
  input  logic       vcc_lt_latchend,
  output logic       hv_en
);
  logic keep_q;   // self-supply hysteresis while running/holding
  logic lchg_q;   // charge hysteresis while latched

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
      lchg_q <= 1'b0;
    end else begin
      keep_q <= is_active(state) ? hyst_next(keep_q, vcc_lt_min, vcc_ge_start) : 1'b0;
      lchg_q <= (state == ST_LATCH) ? hyst_next(lchg_q, vcc_lt_latchend, vcc_ge_start) : 1'b0;
    end
  end

  always_comb begin
    unique case (state)
      ST_OFF:            hv_en = 1'b1;
      ST_RUN, ST_HOLD:   hv_en = keep_q;
      ST_PCHG1, ST_PCHG2: hv_en = 1'b1;
      ST_LATCH:          hv_en = lchg_q;
      default:           hv_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfs_seq_fsm.sv
`timescale 1ns/1ps
module pfs_seq_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_any,
  input  logic       prot_trip,
  input  logic       perm_latch,
  input  logic       vcc_ge_start,
  input  logic       vcc_lt_latchend,
  input  logic       vcc_lt_release,
  output pfs_state_e state,
  output logic       softstart_req
);
  pfs_state_e st_q, nxt;
  logic       ss_q;

  always_comb begin
    nxt = st_q;
    if (st_q == ST_LATCH) begin
      if (vcc_lt_release) nxt = ST_OFF;
    end else if (perm_latch) begin
      nxt = ST_LATCH;
    end else begin
      case (st_q)
        ST_OFF:          if (vcc_ge_start) nxt = start_target(stop_any);
        ST_RUN, ST_HOLD: nxt = prot_trip ? ST_PDIS1 : start_target(stop_any);
        ST_PDIS1:        if (vcc_lt_latchend) nxt = ST_PCHG1;
        ST_PCHG1:        if (vcc_ge_start) nxt = ST_PDIS2;
        ST_PDIS2:        if (vcc_lt_latchend) nxt = ST_PCHG2;
        ST_PCHG2:        if (vcc_ge_start) nxt = start_target(stop_any);
        default:         nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      ss_q <= 1'b0;
    end else begin
      st_q <= nxt;
      ss_q <= (nxt == ST_RUN) && (st_q != ST_RUN);
    end
  end

  assign state         = st_q;
  assign softstart_req = ss_q;
endmodule

// File: rtl/pwr_fault_supervisor.sv
`timescale 1ns/1ps
module pwr_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned FAULT_TICKS = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       overload,
  input  logic       brownout,
  input  logic       ext_disable,
  input  logic       perm_latch,
  input  logic       vcc_ovp,
  input  logic       over_temp,
  input  logic       vcc_ge_start,
  input  logic       vcc_lt_min,
  input  logic       vcc_lt_latchend,
  input  logic       vcc_lt_uv,
  input  logic       vcc_lt_release,
  input  logic       hv_active,
  output logic       pulse_en,
  output logic       hv_en,
  output logic       softstart_req,
  output logic [2:0] state_o
);
  pfs_state_e state;
  logic stop_any, uv_trip, tmr_run, tmr_expired, tmr_idle, prot_trip;

  assign stop_any  = vcc_ovp | brownout | ext_disable | over_temp;
  assign uv_trip   = hv_active & vcc_lt_uv;
  assign tmr_run   = overload & is_active(state);
  assign prot_trip = tmr_expired | uv_trip;

  pfs_fault_timer #(.FAULT_TICKS(FAULT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(tmr_run),
    .expired(tmr_expired), .idle(tmr_idle)
  );

  pfs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_any(stop_any), .prot_trip(prot_trip),
    .perm_latch(perm_latch), .vcc_ge_start(vcc_ge_start),
    .vcc_lt_latchend(vcc_lt_latchend), .vcc_lt_release(vcc_lt_release),
    .state(state), .softstart_req(softstart_req)
  );

  pfs_supply_ctrl u_sup (
    .clk(clk), .rst_n(rst_n), .state(state), .vcc_ge_start(vcc_ge_start),
    .vcc_lt_min(vcc_lt_min), .vcc_lt_latchend(vcc_lt_latchend), .hv_en(hv_en)
  );

  assign pulse_en = (state == ST_RUN);
  assign state_o  = state;
endmodule

// File: rtl/pfs_checker.sv
`timescale 1ns/1ps
module pfs_checker
  import pfs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       softstart_req,
  input logic       tmr_expired,
  input logic       tmr_idle,
  input logic       overload,
  input logic       perm_latch,
  input logic       hv_active,
  input logic       vcc_lt_uv,
  input logic       vcc_ge_start,
  input logic       vcc_lt_release
);
  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_req |=> !softstart_req); // R10

  AST_SS_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_req |-> (state == ST_RUN)); // R10

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !overload |=> tmr_idle); // R3

  AST_EXPIRE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && (state == ST_RUN || state == ST_HOLD) && !perm_latch)
      |=> (state == ST_PDIS1)); // R4

  AST_UV_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN || state == ST_HOLD) && hv_active && vcc_lt_uv && !perm_latch)
      |=> (state == ST_PDIS1)); // R7

  AST_FIRST_CHARGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PCHG1 && vcc_ge_start && !perm_latch) |=> (state == ST_PDIS2)); // R5

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH && !vcc_lt_release) |=> (state == ST_LATCH)); // R8

  AST_LATCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_latch && state != ST_LATCH) |=> (state == ST_LATCH)); // R9
endmodule

bind pwr_fault_supervisor pfs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_o), .softstart_req(softstart_req),
  .tmr_expired(tmr_expired), .tmr_idle(tmr_idle), .overload(overload),
  .perm_latch(perm_latch), .hv_active(hv_active), .vcc_lt_uv(vcc_lt_uv),
  .vcc_ge_start(vcc_ge_start), .vcc_lt_release(vcc_lt_release)
);

// File: tb/sim_pwr_fault_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_fault_supervisor;
  localparam int unsigned FT = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic overload = 0, brownout = 0, ext_disable = 0, perm_latch = 0, vcc_ovp = 0, over_temp = 0;
  logic vcc_ge_start = 0, vcc_lt_min = 1, vcc_lt_latchend = 1, vcc_lt_uv = 1, vcc_lt_release = 1;
  logic hv_active = 0;
  logic pulse_en, hv_en, softstart_req;
  logic [2:0] state_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_fault_supervisor #(.FAULT_TICKS(FT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .overload(overload), .brownout(brownout),
    .ext_disable(ext_disable), .perm_latch(perm_latch), .vcc_ovp(vcc_ovp),
    .over_temp(over_temp), .vcc_ge_start(vcc_ge_start), .vcc_lt_min(vcc_lt_min),
    .vcc_lt_latchend(vcc_lt_latchend), .vcc_lt_uv(vcc_lt_uv),
    .vcc_lt_release(vcc_lt_release), .hv_active(hv_active), .pulse_en(pulse_en),
    .hv_en(hv_en), .softstart_req(softstart_req), .state_o(state_o)
  );

  // bench model of the comparator thresholds, millivolts
  task automatic set_vcc(int mv);
    vcc_ge_start    = (mv >= 12000);
    vcc_lt_min      = (mv < 10000);
    vcc_lt_uv       = (mv < 9000);
    vcc_lt_latchend = (mv < 5000);
    vcc_lt_release  = (mv < 4000);
  endtask

  function automatic int exp_active(bit stop);
    return stop ? 2 : 1;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // walk protection from state 3 back to run, supply currently high
  task automatic prot_walk();
    chk("R5 parked in discharge-1", int'(state_o), 3);
    step();
    chk("R5 discharge-1 waits for latch-end", int'(state_o), 3);
    chk("R5 source off in discharge-1", int'(hv_en), 0);
    set_vcc(4900); step();
    chk("R5 charge-1", int'(state_o), 4);
    chk("R5 source on in charge-1", int'(hv_en), 1);
    set_vcc(12000); step();
    chk("R5 first recharge keeps output off", int'(state_o), 5);
    chk("R5 no pulses", int'(pulse_en), 0);
    set_vcc(4900); step();
    chk("R5 charge-2", int'(state_o), 6);
    set_vcc(12000); step();
    chk("R5 second recharge releases", int'(state_o), 1);
    chk("R10 soft-start after protection", int'(softstart_req), 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    set_vcc(0);
    step(); step();
    chk("R1 reset state off", int'(state_o), 0);
    chk("R1 reset pulses off", int'(pulse_en), 0);
    chk("R1 reset source on", int'(hv_en), 1);
    chk("R10 no soft-start at reset", int'(softstart_req), 0);
    rst_n = 1'b1; step();
    set_vcc(11000); step();
    chk("R1 waits for start level", int'(state_o), 0);
    set_vcc(12000); step();
    chk("R1 start to run", int'(state_o), 1);
    chk("R1 pulses on", int'(pulse_en), 1);
    chk("R10 soft-start pulse", int'(softstart_req), 1);
    step();
    chk("R10 soft-start one cycle", int'(softstart_req), 0);

    // R6 self-supply hysteresis
    chk("R6 source off above min", int'(hv_en), 0);
    set_vcc(9500); hv_active = 1; step();
    chk("R6 source on below min", int'(hv_en), 1);
    set_vcc(11000); step();
    chk("R6 source holds in band", int'(hv_en), 1);
    chk("R7 no trip above low threshold", int'(state_o), 1);
    set_vcc(12500); step();
    chk("R6 source off at start", int'(hv_en), 0);
    hv_active = 0; set_vcc(12000);

    // R2 random stop conditions
    begin
      int prev = 1;
      for (int i = 0; i < 40; i++) begin
        logic [3:0] f = 4'($urandom) & 4'($urandom);
        bit stop = |f;
        vcc_ovp = f[0]; brownout = f[1]; ext_disable = f[2]; over_temp = f[3];
        step();
        chk("R2 stop condition state", int'(state_o), exp_active(stop));
        chk("R2 pulses follow stop", int'(pulse_en), stop ? 0 : 1);
        chk("R10 soft-start on resume", int'(softstart_req), (prev == 2 && !stop) ? 1 : 0);
        prev = exp_active(stop);
      end
      {vcc_ovp, brownout, ext_disable, over_temp} = '0;
      step();
    end

    // R3 timer clear and expiry
    overload = 1;
    for (int i = 0; i < FT - 1; i++) do_tick();
    chk("R3 not yet expired", int'(state_o), 1);
    overload = 0; step(); overload = 1;
    for (int i = 0; i < FT - 1; i++) do_tick();
    chk("R3 release restarted timer", int'(state_o), 1);
    do_tick();
    chk("R3 expiry seen next edge", int'(state_o), 1);
    overload = 0; step();
    chk("R3 protection entered", int'(state_o), 3);
    chk("R3 pulses stop", int'(pulse_en), 0);
    prot_walk();

    // R4 timer runs during hold
    brownout = 1; step();
    chk("R4 hold", int'(state_o), 2);
    overload = 1;
    for (int i = 0; i < FT; i++) do_tick();
    step();
    chk("R4 expiry from hold", int'(state_o), 3);
    overload = 0; brownout = 0;
    prot_walk();

    // R7 low supply with source on
    set_vcc(8900); hv_active = 0; step(); step();
    chk("R7 no trip with source off", int'(state_o), 1);
    hv_active = 1; step();
    chk("R7 trip with source on", int'(state_o), 3);
    hv_active = 0; set_vcc(12000);
    prot_walk();

    // R8 / R9 permanent latch with a stop condition present
    vcc_ovp = 1; perm_latch = 1; step();
    chk("R9 latch beats stop", int'(state_o), 7);
    vcc_ovp = 0; perm_latch = 0;
    chk("R8 latched source off", int'(hv_en), 0);
    set_vcc(4900); step();
    chk("R8 latched source on", int'(hv_en), 1);
    chk("R8 latched pulses off", int'(pulse_en), 0);
    set_vcc(12000); step();
    chk("R8 latched source off at start", int'(hv_en), 0);
    chk("R8 still latched", int'(state_o), 7);
    set_vcc(4500); step();
    chk("R8 latched above release", int'(state_o), 7);
    set_vcc(3900); step();
    chk("R8 release to off", int'(state_o), 0);
    chk("R1 off source on", int'(hv_en), 1);
    ext_disable = 1; set_vcc(12000); step();
    chk("R1 start into hold", int'(state_o), 2);
    ext_disable = 0; step();
    chk("R2 resume run", int'(state_o), 1);
    chk("R10 soft-start from hold", int'(softstart_req), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule